// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches a set of general-purpose input lines and raises one combined interrupt request when any unmasked line shows its selected condition. Every line has its own setting for level or edge sensitivity, for one edge or both, and for active polarity. Edge events are held in a per-line latch until software acknowledges them. Level conditions track the line and are never held.

Software uses a simple synchronous register port. Every register is a 32-bit word that holds one bit per line, and the lines are spread over as many words (banks) as the line count needs. The lines are asynchronous to the clock and pass through a two-stage synchroniser before any detection. Software can read per-line status before the mask is applied and after it.

To acknowledge a held edge event, software writes the line's clear bit to 0 and then back to 1. While the clear bit is 0 the latch stays empty and ignores new edges.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `irq_out` is 0. After reset the trigger, both-edge, polarity and enable registers read 0, and the clear register reads all ones (every latch armed).
- R2: `reg_addr` is {select[2:0], bank}. Select codes: 0 trigger-type, 1 both-edges, 2 polarity, 3 enable, 4 clear, 5 raw status (read-only), 6 masked status (read-only). Line n is bit n%32 of bank n/32.
- R3: When the trigger bit is 0 (level mode), a line's raw status equals the synchronised line value if its polarity bit is 1, and the inverse of that value if its polarity bit is 0. Level status is not held and the both-edges bit has no effect.
- R4: When the trigger bit is 1, both-edges is 0 and polarity is 1, a 0-to-1 change of the synchronised line sets the line's latch. A 1-to-0 change does not.
- R5: When the trigger bit is 1, both-edges is 0 and polarity is 0, a 1-to-0 change sets the latch. A 0-to-1 change does not.
- R6: When the trigger bit is 1 and both-edges is 1, either change sets the latch, whatever the polarity bit is. In edge mode, raw status is the latch.
- R7: While a line's clear bit is 0, its latch is empty and edges on the line are lost. After the bit returns to 1, later edges are latched again.
- R8: Masked status is raw status ANDed with the enable bits. `irq_out` is the registered OR of all masked status bits.
- R9: A line's latch captures edges while the line is masked. The captured event drives `irq_out` once the line is unmasked.
- R10: A line change that is sampled at clock edge k reaches detection after edge k+1. Level status reaches `irq_out` at edge k+2. An edge latch sets at edge k+2 and reaches `irq_out` at edge k+3. `reg_rdata` is registered, so it shows the word addressed before the previous edge.
- R11: Writes to the status addresses and to the unused select code 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | SEL_W+BANK_W | Register select and bank |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous input lines |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The assertions assume that reset is held for at least one clock at time zero, so the first comparison with a past value sees reset contents. They also assume that a write to the clear register is the only thing that can empty a latch. The bench holds reset for several cycles and changes inputs only on the falling clock edge. After each line change it waits at least five cycles, so every edge passes through the synchroniser before status is read. It drives clear-register writes as complete pairs, one write of 0 followed by one write of 1, and it also checks that an edge arriving between the two writes is lost.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TRIG = 3'd0,
    SEL_BOTH = 3'd1,
    SEL_POL  = 3'd2,
    SEL_EN   = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_RAW  = 3'd5,
    SEL_MSK  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int WORD_W    = 32,
  parameter int BANK_W    = 1,
  localparam int TOT      = NUM_BANKS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  reg_sel_e          sel,
  input  logic [BANK_W-1:0] bank,
  input  logic [WORD_W-1:0] wdata,
  output logic [TOT-1:0]    trig_q,
  output logic [TOT-1:0]    both_q,
  output logic [TOT-1:0]    pol_q,
  output logic [TOT-1:0]    en_q,
  output logic [TOT-1:0]    clr_q
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] BIDX = BANK_W'(b);

    always_ff @(posedge clk) begin
      if (rst) begin
        trig_q[b*WORD_W +: WORD_W] <= '0;
        both_q[b*WORD_W +: WORD_W] <= '0;
        pol_q[b*WORD_W +: WORD_W]  <= '0;
        en_q[b*WORD_W +: WORD_W]   <= '0;
        clr_q[b*WORD_W +: WORD_W]  <= '1;
      end else if (we && bank == BIDX) begin
        case (sel)
          SEL_TRIG: trig_q[b*WORD_W +: WORD_W] <= wdata;
          SEL_BOTH: both_q[b*WORD_W +: WORD_W] <= wdata;
          SEL_POL:  pol_q[b*WORD_W +: WORD_W]  <= wdata;
          SEL_EN:   en_q[b*WORD_W +: WORD_W]   <= wdata;
          SEL_CLR:  clr_q[b*WORD_W +: WORD_W]  <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  input  logic trig_edge,
  input  logic both,
  input  logic pol,
  input  logic arm,
  output logic lat,
  output logic raw
);
  logic prev;
  logic hit;

  always_comb begin
    if (!trig_edge)  hit = 1'b0;
    else if (both)   hit = smp ^ prev;
    else if (pol)    hit = smp & ~prev;
    else             hit = ~smp & prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      lat  <= 1'b0;
    end else begin
      prev <= smp;
      lat  <= arm ? (lat | hit) : 1'b0;
    end
  end

  assign raw = trig_edge ? lat : (smp ~^ pol);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int WORD_W     = 32,
  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = SEL_W + BANK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                irq_out
);
  localparam int TOT   = NUM_BANKS * WORD_W;
  localparam int PAD_W = (1 << BANK_W) * WORD_W;

  reg_sel_e          sel;
  logic [BANK_W-1:0] bank;
  logic [TOT-1:0]    smp_vec;
  logic [TOT-1:0]    trig_q, both_q, pol_q, en_q, clr_q;
  logic [TOT-1:0]    edge_lat, raw_stat, msk_stat;
  logic [TOT-1:0]    rd_vec;
  logic [PAD_W-1:0]  rd_pad;

  assign sel  = reg_sel_e'(reg_addr[ADDR_W-1 -: SEL_W]);
  assign bank = reg_addr[BANK_W-1:0];

  gpio_irq_sync #(.W(TOT)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (TOT'(pin_in)),
    .q   (smp_vec)
  );

  gpio_irq_cfg #(
    .NUM_BANKS (NUM_BANKS),
    .WORD_W    (WORD_W),
    .BANK_W    (BANK_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .sel    (sel),
    .bank   (bank),
    .wdata  (reg_wdata),
    .trig_q (trig_q),
    .both_q (both_q),
    .pol_q  (pol_q),
    .en_q   (en_q),
    .clr_q  (clr_q)
  );

  for (genvar i = 0; i < TOT; i++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk       (clk),
      .rst       (rst),
      .smp       (smp_vec[i]),
      .trig_edge (trig_q[i]),
      .both      (both_q[i]),
      .pol       (pol_q[i]),
      .arm       (clr_q[i]),
      .lat       (edge_lat[i]),
      .raw       (raw_stat[i])
    );
  end

  assign msk_stat = raw_stat & en_q;

  always_comb begin
    case (sel)
      SEL_TRIG: rd_vec = trig_q;
      SEL_BOTH: rd_vec = both_q;
      SEL_POL:  rd_vec = pol_q;
      SEL_EN:   rd_vec = en_q;
      SEL_CLR:  rd_vec = clr_q;
      SEL_RAW:  rd_vec = raw_stat;
      SEL_MSK:  rd_vec = msk_stat;
      default:  rd_vec = '0;
    endcase
  end

  assign rd_pad = PAD_W'(rd_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq_out   <= |msk_stat;
      reg_rdata <= rd_pad[bank*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int TOT = 64
) (
  input logic           clk,
  input logic           rst,
  input logic           irq_out,
  input logic [TOT-1:0] lat,
  input logic [TOT-1:0] clr_q,
  input logic [TOT-1:0] en_q,
  input logic [TOT-1:0] raw
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !irq_out);

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|(raw & en_q)));

  // R7
  hold_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (lat & ~$past(clr_q)) == '0);

  // R9
  sticky_lat_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lat) & $past(clr_q) & ~lat) == '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.TOT(TOT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_out (irq_out),
  .lat     (edge_lat),
  .clr_q   (clr_q),
  .en_q    (en_q),
  .raw     (raw_stat)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pins = '0;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pins),
    .irq_out   (irq_out)
  );

  // behavioural reference model
  logic [63:0] m_s1, m_s2, m_old, m_trig, m_both, m_pol, m_en, m_clr, m_lat;
  logic        m_irq;
  logic [31:0] m_rd;

  function automatic logic [63:0] m_raw();
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (m_trig[i]) r[i] = m_lat[i];
      else if (m_pol[i]) r[i] = m_s2[i];
      else r[i] = !m_s2[i];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [63:0] raw_now, word_src, lat_next;
    int sel, bk;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_old = '0; m_lat = '0;
      m_trig = '0; m_both = '0; m_pol = '0; m_en = '0; m_clr = '1;
      m_irq = 1'b0; m_rd = '0;
    end else begin
      raw_now = m_raw();
      sel = int'(reg_addr) / 2;
      bk  = int'(reg_addr) % 2;
      case (sel)
        0: word_src = m_trig;
        1: word_src = m_both;
        2: word_src = m_pol;
        3: word_src = m_en;
        4: word_src = m_clr;
        5: word_src = raw_now;
        6: word_src = raw_now & m_en;
        default: word_src = '0;
      endcase
      m_rd  = (bk == 0) ? word_src[31:0] : word_src[63:32];
      m_irq = ((raw_now & m_en) != 0);
      for (int i = 0; i < 64; i++) begin
        bit rose, fell, got;
        rose = m_s2[i] && !m_old[i];
        fell = !m_s2[i] && m_old[i];
        got  = 0;
        if (m_trig[i]) begin
          if (m_both[i]) got = rose || fell;
          else if (m_pol[i]) got = rose;
          else got = fell;
        end
        if (!m_clr[i]) lat_next[i] = 1'b0;
        else lat_next[i] = m_lat[i] || got;
      end
      m_lat = lat_next;
      m_old = m_s2;
      m_s2  = m_s1;
      m_s1  = pins;
      if (reg_we && sel < 5) begin
        case (sel)
          0: if (bk == 0) m_trig[31:0] = reg_wdata; else m_trig[63:32] = reg_wdata;
          1: if (bk == 0) m_both[31:0] = reg_wdata; else m_both[63:32] = reg_wdata;
          2: if (bk == 0) m_pol[31:0]  = reg_wdata; else m_pol[63:32]  = reg_wdata;
          3: if (bk == 0) m_en[31:0]   = reg_wdata; else m_en[63:32]   = reg_wdata;
          default: if (bk == 0) m_clr[31:0] = reg_wdata; else m_clr[63:32] = reg_wdata;
        endcase
      end
    end
  end

  // per-cycle comparison against the model (R10 timing)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq_out !== m_irq) begin
        errors++;
        $display("FAIL R10 irq_out actual=%0b expected=%0b t=%0t", irq_out, m_irq, $time);
      end
      checks++;
      if (reg_rdata !== m_rd) begin
        errors++;
        $display("FAIL R10 reg_rdata actual=%h expected=%h t=%0t", reg_rdata, m_rd, $time);
      end
    end
  end

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk32(tag, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(4);
    chk1("R1 irq during reset", irq_out, 1'b0);
    rst = 1'b0;
    cyc(1);
    chk1("R1 irq after reset", irq_out, 1'b0);
    rd(4'd0, "R1 trigger bank0", 32'h0);
    rd(4'd7, "R1 enable bank1", 32'h0);
    rd(4'd8, "R1 clear bank0", 32'hFFFF_FFFF);
    rd(4'd10, "R3 raw level-low idle", 32'hFFFF_FFFF);

    // level mode
    wr(4'd4, 32'h0000_000F);
    wr(4'd2, 32'h0000_0001);
    pins[0] = 1'b1;
    cyc(5);
    rd(4'd10, "R3 level high seen", 32'hFFFF_FFF1);
    pins[0] = 1'b0;
    cyc(5);
    rd(4'd10, "R3 level not held", 32'hFFFF_FFF0);
    wr(4'd2, 32'h0);

    // single edges on bank1
    pins[63:48] = 16'hFFFF;
    cyc(5);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd5, 32'h0000_FFFF);
    rd(4'd11, "R4 no event yet", 32'h0);
    pins[32] = 1'b1; pins[48] = 1'b0;
    cyc(5);
    pins[32] = 1'b0; pins[48] = 1'b1;
    cyc(5);
    rd(4'd11, "R5 rise and fall latched", 32'h0001_0001);
    chk1("R8 masked lines quiet", irq_out, 1'b0);

    // unmask after the event
    wr(4'd7, 32'h0000_0001);
    cyc(3);
    chk1("R9 event while masked", irq_out, 1'b1);
    rd(4'd13, "R8 masked status", 32'h0000_0001);

    // acknowledge sequence
    wr(4'd9, 32'hFFFF_FFFE);
    cyc(3);
    chk1("R7 cleared irq", irq_out, 1'b0);
    pins[32] = 1'b1;
    cyc(5);
    rd(4'd11, "R7 held empty", 32'h0001_0000);
    wr(4'd9, 32'hFFFF_FFFF);
    cyc(5);
    rd(4'd11, "R7 edge during hold lost", 32'h0001_0000);
    pins[32] = 1'b0;
    cyc(5);
    pins[32] = 1'b1;
    cyc(5);
    rd(4'd11, "R4 re-armed rise", 32'h0001_0001);

    // both edges, polarity bit 0
    wr(4'd2, 32'h0000_0100);
    wr(4'd0, 32'h0000_0100);
    cyc(3);
    rd(4'd10, "R6 empty edge line", 32'hFFFF_FEF0);
    pins[8] = 1'b1;
    cyc(5);
    rd(4'd10, "R6 rise with pol 0", 32'hFFFF_FFF0);
    wr(4'd8, 32'hFFFF_FEFF);
    wr(4'd8, 32'hFFFF_FFFF);
    cyc(3);
    rd(4'd10, "R7 ack bank0", 32'hFFFF_FEF0);
    pins[8] = 1'b0;
    cyc(5);
    rd(4'd10, "R6 fall", 32'hFFFF_FFF0);

    // read-only and unused addresses
    wr(4'd11, 32'h0);
    rd(4'd11, "R11 raw unchanged", 32'h0001_0001);
    wr(4'd14, 32'hFFFF_FFFF);
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd0, "R11 trigger unchanged", 32'h0000_0100);
    rd(4'd6, "R11 enable unchanged", 32'h0);

    // top line of the top bank
    wr(4'd7, 32'h8000_0000);
    cyc(3);
    chk1("R8 only line 63 enabled", irq_out, 1'b0);
    pins[63] = 1'b0;
    cyc(5);
    rd(4'd11, "R2 line 63 at bank1 bit31", 32'h8001_0001);
    rd(4'd13, "R2 masked line 63", 32'h8000_0000);
    chk1("R2 irq from line 63", irq_out, 1'b1);

    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule